// File: doc/BRIEF.md
# ADC conversion control sequencer

This block is the digital control and status logic that sits next to a successive-approximation converter. Software sees one 8-bit control/status register. Through it, software switches the converter on, starts conversions, arms automatic starts from a trigger line, enables an interrupt and picks the converter clock divider. The block divides the system clock down to a converter tick and counts ticks through each conversion. When a conversion ends, it latches a 10-bit sample and raises a completion flag. That flag, combined with a local and a global enable, drives the interrupt request.

The register bits are fixed: bit 7 enable, bit 6 start/busy, bit 5 auto-trigger enable, bit 4 completion flag (write 1 to clear), bit 3 interrupt enable, bits 2:0 divider code. A register write is a single-cycle `reg_wr_en` pulse. `reg_rdata` always shows the current register state. There is no streaming interface at this block's edge. The latched result is a plain status output with no back-pressure: it holds its value until the next completed conversion overwrites it.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the register reads 8'h00, `irq` is 0 and `result` is 0.
- R2: Writing a 1 to bit 6 while bit 7 is being written as 1 starts a conversion. Bit 6 then reads 1 until the conversion ends, and returns to 0 by itself. Writing 0 to bit 6 during a conversion changes nothing.
- R3: A conversion lasts 25 converter ticks if it is the first since the enable went from 0 to 1, and 13 ticks otherwise. The first-conversion case includes enable and start written in the same write.
- R4: Divider code 0 and code 1 both give a tick every 2 system cycles. Code k, for k from 2 to 7, gives a tick every 2^k system cycles. The divider phase is cleared while the block is disabled. As a result, a conversion started in the same write that enables the block keeps bit 6 high for exactly length x divisor system cycles.
- R5: With bit 5 set, a 0-to-1 edge on `trig_in` starts a conversion, and bit 6 reads 1 in the next cycle. A trigger held high causes no further start. With bit 5 clear, a trigger edge starts nothing.
- R6: A start write or a trigger edge that arrives during a conversion is ignored: that conversion neither restarts nor gets longer.
- R7: On the last tick of a conversion, `result` takes `smp_data` and bit 4 sets, both in the same cycle. `result` holds its value at all other times.
- R8: Writing 1 to bit 4 clears the flag, and so does a pulse on `irq_ack`. Writing 0 to bit 4 leaves the flag as it is.
- R9: `irq` is 1 exactly when the flag, bit 3 and `gie` are all 1.
- R10: Writing 0 to bit 7 during a conversion aborts it. Bit 6 is 0 in the next cycle, the flag does not set and `result` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | One-cycle register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Current register contents |
| trig_in | input | 1 | Auto-trigger input, rising edge sensitive |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| smp_data | input | 10 | Converter sample value |
| result | output | 10 | Latched conversion result |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 10-bit result, a 7-bit divider counter and conversion lengths of 25 and 13 ticks. With these values every divider code can be reached, including divide-by-128. Because the divider phase is cleared on enable, the length of a first conversion can be checked to the exact cycle for all eight codes. The length of a later conversion depends on the free-running divider phase, so it is checked against a one-tick window.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned BIT_EN  = 7;
  localparam int unsigned BIT_GO  = 6;
  localparam int unsigned BIT_ATE = 5;
  localparam int unsigned BIT_FLG = 4;
  localparam int unsigned BIT_IE  = 3;

  // log2 of the divisor for a divider code; codes 0 and 1 both mean /2
  function automatic logic [2:0] div_shift(input logic [2:0] code);
    return (code == 3'd0) ? 3'd1 : code;
  endfunction
endpackage

// File: rtl/adc_psc_div.sv
module adc_psc_div #(
  parameter int unsigned PSC_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] sel,
  output logic       tick
);
  import adc_seq_pkg::*;

  logic [PSC_W-1:0] cnt_q;
  logic [PSC_W-1:0] mask;

  always_comb begin
    mask = (PSC_W'(1) << div_shift(sel)) - PSC_W'(1);
    tick = run && ((cnt_q & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (run) cnt_q <= cnt_q + PSC_W'(1);
    else          cnt_q <= '0;
  end

  AST_NO_EARLY_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !$past(run)) |-> !tick); // R4
endmodule

// File: rtl/adc_conv_ctr.sv
module adc_conv_ctr #(
  parameter int unsigned LEN_FIRST = 25,
  parameter int unsigned LEN_NORM  = 13,
  localparam int unsigned CNT_W    = $clog2(LEN_FIRST + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic start,
  input  logic tick,
  output logic busy,
  output logic done
);
  localparam logic [CNT_W-1:0] LF = CNT_W'(LEN_FIRST);
  localparam logic [CNT_W-1:0] LN = CNT_W'(LEN_NORM);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_q;
  logic             busy_q;
  logic             first_q;

  assign busy = busy_q;
  assign done = en && busy_q && tick && (cnt_q == len_q - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      len_q   <= LN;
      first_q <= 1'b1;
    end else if (!en) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      first_q <= 1'b1;
    end else if (start && !busy_q) begin
      busy_q  <= 1'b1;
      cnt_q   <= '0;
      len_q   <= first_q ? LF : LN;
      first_q <= 1'b0;
    end else if (done) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q && tick) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < len_q)); // R3
  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (len_q == LF || len_q == LN)); // R3
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q); // R2
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int unsigned RES_W     = 10,
  parameter int unsigned PSC_W     = 7,
  parameter int unsigned LEN_FIRST = 25,
  parameter int unsigned LEN_NORM  = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             trig_in,
  input  logic             gie,
  input  logic             irq_ack,
  input  logic [RES_W-1:0] smp_data,
  output logic [RES_W-1:0] result,
  output logic             irq
);
  import adc_seq_pkg::*;

  logic             en_q, ate_q, ie_q, flag_q, trig_q;
  logic [2:0]       psc_q;
  logic [RES_W-1:0] res_q;
  logic             en_nxt, start_req, tick, busy, conv_done, flag_clr;

  always_comb begin
    en_nxt    = reg_wr_en ? reg_wdata[BIT_EN] : en_q;
    start_req = (reg_wr_en && reg_wdata[BIT_GO]) || (ate_q && trig_in && !trig_q);
    flag_clr  = (reg_wr_en && reg_wdata[BIT_FLG]) || irq_ack;
  end

  adc_psc_div #(.PSC_W(PSC_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(en_q), .sel(psc_q), .tick(tick)
  );

  adc_conv_ctr #(.LEN_FIRST(LEN_FIRST), .LEN_NORM(LEN_NORM)) u_ctr (
    .clk(clk), .rst_n(rst_n), .en(en_nxt), .start(start_req), .tick(tick),
    .busy(busy), .done(conv_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      ate_q  <= 1'b0;
      ie_q   <= 1'b0;
      psc_q  <= 3'd0;
      flag_q <= 1'b0;
      trig_q <= 1'b0;
      res_q  <= '0;
    end else begin
      trig_q <= trig_in;
      en_q   <= en_nxt;
      if (reg_wr_en) begin
        ate_q <= reg_wdata[BIT_ATE];
        ie_q  <= reg_wdata[BIT_IE];
        psc_q <= reg_wdata[2:0];
      end
      if (conv_done) begin
        flag_q <= 1'b1;
        res_q  <= smp_data;
      end else if (flag_clr) begin
        flag_q <= 1'b0;
      end
    end
  end

  assign reg_rdata = {en_q, busy, ate_q, flag_q, ie_q, psc_q};
  assign result    = res_q;
  assign irq       = flag_q && ie_q && gie;

  AST_BUSY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> en_q); // R10
  AST_FLAG_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && en_q) |-> flag_q); // R7
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !conv_done) |=> !flag_q); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(conv_done) |-> $stable(res_q)); // R7
endmodule

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       trig_in = 1'b0, gie = 1'b0, irq_ack = 1'b0, irq;
  logic [9:0] smp_data = 10'd0, result;

  int checks = 0, errs = 0, cyc = 0;

  always #2 clk = ~clk; // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  adc_seq_ctrl u_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .trig_in(trig_in), .gie(gie), .irq_ack(irq_ack),
    .smp_data(smp_data), .result(result), .irq(irq)
  );

  // {divider code, divisor, sample value}
  localparam logic [20:0] VEC [8] = '{
    {3'd0, 8'd2,   10'h015}, {3'd1, 8'd2,   10'h3A2},
    {3'd2, 8'd4,   10'h1C7}, {3'd3, 8'd8,   10'h0F0},
    {3'd4, 8'd16,  10'h2AB}, {3'd5, 8'd32,  10'h155},
    {3'd6, 8'd64,  10'h3FF}, {3'd7, 8'd128, 10'h001}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); reg_wr_en = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr_en = 1'b0;
  endtask

  task automatic measure(output int n);
    n = 0;
    while (reg_rdata[6] && n < 6000) begin n++; @(negedge clk); end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    int n, t0, div;
    logic [2:0] code;
    logic [9:0] smp, held;
    repeat (3) @(negedge clk);
    chk(reg_rdata == 8'h00, "R1 reg", reg_rdata, 0);
    chk(irq == 1'b0 && result == 10'd0, "R1 irq/result", {irq, result}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++) begin
      code = VEC[i][20:18]; div = int'(VEC[i][17:10]); smp = VEC[i][9:0];
      wr(8'h10);
      smp_data = smp;
      wr(8'hC0 | 8'(code));
      chk(reg_rdata[6], "R2 busy after start", reg_rdata[6], 1);
      measure(n);
      chk(n == 25 * div, "R3 R4 first length", n, 25 * div);
      chk(reg_rdata[4] && result == smp, "R7 flag/result", result, smp);
      wr(8'h90 | 8'(code));
      chk(!reg_rdata[4], "R8 write-1 clear", reg_rdata[4], 0);
      wr(8'hC0 | 8'(code));
      measure(n);
      chk(n >= 12 * div + 1 && n <= 13 * div, "R3 R4 later length", n, 13 * div);
    end

    // R2 R6: restart and write-0 during busy
    wr(8'h90);
    wr(8'hC0); t0 = cyc;
    repeat (3) @(negedge clk);
    wr(8'hC0);
    wr(8'h80);
    chk(reg_rdata[6], "R2 write-0 keeps busy", reg_rdata[6], 1);
    measure(n);
    chk(cyc - t0 <= 27 && cyc - t0 >= 25, "R6 no restart", cyc - t0, 26);

    // R8 R9: flag handling and interrupt gating
    wr(8'h80);
    chk(reg_rdata[4], "R8 write-0 keeps flag", reg_rdata[4], 1);
    wr(8'h88);
    chk(!irq, "R9 gie low", irq, 0);
    gie = 1'b1; @(negedge clk);
    chk(irq, "R9 all set", irq, 1);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    chk(!reg_rdata[4] && !irq, "R8 ack clears", {reg_rdata[4], irq}, 0);

    // R5: auto-trigger
    wr(8'hA0);
    trig_in = 1'b1; @(negedge clk);
    chk(reg_rdata[6], "R5 edge starts", reg_rdata[6], 1);
    measure(n);
    repeat (10) @(negedge clk);
    chk(!reg_rdata[6], "R5 level no restart", reg_rdata[6], 0);
    trig_in = 1'b0;
    wr(8'h90);
    trig_in = 1'b1; repeat (2) @(negedge clk);
    chk(!reg_rdata[6], "R5 disarmed", reg_rdata[6], 0);
    trig_in = 1'b0;

    // R10: abort
    held = result;
    wr(8'hD0);
    smp_data = ~held;
    repeat (6) @(negedge clk);
    wr(8'h00);
    chk(!reg_rdata[6], "R10 busy drops", reg_rdata[6], 0);
    repeat (60) @(negedge clk);
    chk(!reg_rdata[4] && result == held, "R10 no flag/result", result, held);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule